// File: doc/BRIEF.md
# 1-Wire Slave ROM Command Layer

This block is the addressing layer of a single-wire bus slave. It sits above a bit-level timing engine. From that engine it takes reset events, received bits and requests for the bit to drive in each read slot. After each reset it collects an 8-bit ROM command. Depending on the command, it reports its 64-bit identity, compares the identity against one sent by the master, takes part in a bitwise search arbitration, or skips addressing. When addressing succeeds, it grants access to the memory-function layer above it.

The 64-bit identity is fixed at elaboration. It is built from a family code parameter and a serial number parameter, and the block computes the CRC8 byte itself. The block also holds the overdrive flag, which tells the bit engine to use fast timing. Two of the commands set this flag. Only a reset of regular length clears it.

Top module: `ow_rom_layer`

## Requirements
- R1: After rst_ni is released, mem_enable_o=0, overdrive_o=0 and tx_bit_o=1. Received bits are ignored until the first reset_seen_i pulse.
- R2: After each reset_seen_i, the next 8 received bits (rx_valid_i=1) form the command byte, least significant bit first. The command takes effect on the 8th bit and not before.
- R3: The identity sent least significant bit first is: bits 7:0 the family code (default 23h), bits 55:8 the serial number, bits 63:56 the CRC8 of bits 55:0. The CRC8 uses polynomial x^8+x^5+x^4+1, starts at zero, and takes its input bits LSB first.
- R4: Command 33h (read) presents the 64 identity bits in true form on tx_bit_o, one bit per tx_req_i pulse, bit 0 first. After the 64th pulse, mem_enable_o=1.
- R5: Command 55h (match) compares the next 64 received bits with the identity, bit 0 first. If all 64 agree, mem_enable_o=1.
- R6: On the first disagreeing bit of a match, the block drops out until the next reset. In that state mem_enable_o stays 0, tx_bit_o stays 1, and all further bits and commands are ignored.
- R7: Command F0h (search) handles each identity bit i as three steps. The first tx_req_i slot drives bit i. The second tx_req_i slot drives its complement. Then one received bit is taken. If the received bit equals bit i, the block moves to bit i+1. After bit 63 agrees, mem_enable_o=1.
- R8: During search, a received bit that differs from the identity bit makes the block drop out as in R6.
- R9: Command CCh (skip) sets mem_enable_o=1 directly after the command byte. The grant holds until the next reset_seen_i.
- R10: Command 3Ch (overdrive skip) sets overdrive_o=1 and mem_enable_o=1 directly after the command byte.
- R11: Command 69h (overdrive match) sets overdrive_o=1 directly after the command byte, before any address bit. The 64 address bits that follow are then matched as in R5 and R6.
- R12: overdrive_o is cleared only by reset_seen_i together with reset_long_i=1. A reset with reset_long_i=0, a plain match and any other command leave it set.
- R13: Any other command code makes the block drop out as in R6, with no grant.
- R14: reset_seen_i at any point clears mem_enable_o in the next cycle. It also discards any partial command or identity progress, and command reception starts again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reset_seen_i | input | 1 | One-cycle pulse: the bit engine detected a bus reset |
| reset_long_i | input | 1 | Qualifies reset_seen_i: the reset had regular length, so overdrive is cleared |
| rx_valid_i | input | 1 | One-cycle pulse: a bit was received from the master |
| rx_bit_i | input | 1 | Value of the received bit |
| tx_req_i | input | 1 | One-cycle pulse: a read slot consumes tx_bit_o |
| tx_bit_o | output | 1 | Bit to drive in the current read slot (1 leaves the line released) |
| mem_enable_o | output | 1 | Access granted to the memory-function layer |
| overdrive_o | output | 1 | Fast bit timing selected |

## Verification
The command decoder is driven with every defined code, one undefined code, a command cut short by a reset, and a command sent before any reset. Together these separate correct decoding from decoding on the wrong bit count or a missing reset gate. Match and search are each run twice: once with the exact identity, and once with a single wrong bit placed mid-stream. The wrong-bit runs show whether the block drops out at that bit and stays silent afterwards. Read ROM output is compared bit by bit against an identity and CRC8 computed in the bench, so the bench catches bit-order and polynomial errors. Sequences of short resets, long resets and matches show that the overdrive flag is set only by its two commands and cleared only by a long reset.

// File: rtl/ow_rom_pkg.sv
package ow_rom_pkg;

  localparam int unsigned CMD_BITS = 8;
  localparam int unsigned ID_BITS  = 64;

  localparam logic [CMD_BITS-1:0] CMD_READ     = 8'h33;
  localparam logic [CMD_BITS-1:0] CMD_MATCH    = 8'h55;
  localparam logic [CMD_BITS-1:0] CMD_SEARCH   = 8'hF0;
  localparam logic [CMD_BITS-1:0] CMD_SKIP     = 8'hCC;
  localparam logic [CMD_BITS-1:0] CMD_OD_SKIP  = 8'h3C;
  localparam logic [CMD_BITS-1:0] CMD_OD_MATCH = 8'h69;

  // Reflected form of x^8+x^5+x^4+1
  localparam logic [7:0] CRC8_POLY_REFL = 8'h8C;

  typedef enum logic [2:0] {
    ST_WAIT,
    ST_CMD,
    ST_READ,
    ST_MATCH,
    ST_SEARCH,
    ST_GRANT,
    ST_DROP
  } rom_state_e;

  typedef enum logic [1:0] {
    SP_TRUE,
    SP_CMPL,
    SP_DIR
  } search_phase_e;

endpackage

// File: rtl/ow_rom_ident.sv
module ow_rom_ident
  import ow_rom_pkg::*;
#(
  parameter logic [7:0]  FAMILY_CODE = 8'h23,
  parameter logic [47:0] SERIAL_NUM  = 48'hA1B2C3D4E5F6
) (
  output logic [ID_BITS-1:0] id_o
);

  localparam int unsigned BODY_BITS = ID_BITS - 8;

  logic [BODY_BITS-1:0] body;
  logic [7:0]           crc_chain [BODY_BITS+1];

  assign body         = {SERIAL_NUM, FAMILY_CODE};
  assign crc_chain[0] = 8'h00;

  // One serial CRC step per body bit, unrolled; folds to constants
  for (genvar i = 0; i < BODY_BITS; i++) begin : g_crc
    logic fb;
    assign fb             = crc_chain[i][0] ^ body[i];
    assign crc_chain[i+1] = {1'b0, crc_chain[i][7:1]} ^ (fb ? CRC8_POLY_REFL : 8'h00);
  end

  assign id_o = {crc_chain[BODY_BITS], body};

endmodule

// File: rtl/ow_rom_cmd_rx.sv
module ow_rom_cmd_rx #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         bit_i,
  output logic         done_o,
  output logic [W-1:0] code_o
);

  localparam int unsigned CW = $clog2(W);

  logic [CW-1:0] cnt_q;
  logic [W-2:0]  sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (en_i) begin
      cnt_q <= (cnt_q == CW'(W-1)) ? '0 : cnt_q + 1'b1;
      sh_q  <= {bit_i, sh_q[W-2:1]};
    end
  end

  assign done_o = en_i && (cnt_q == CW'(W-1));
  assign code_o = {bit_i, sh_q};

  AST_CMD_CNT_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0) else $error("cmd count not restarted"); // R14

endmodule

// File: rtl/ow_rom_index.sv
module ow_rom_index #(
  parameter int unsigned N = 64
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 inc_i,
  output logic [$clog2(N)-1:0] idx_o,
  output logic                 last_o
);

  localparam int unsigned IW = $clog2(N);

  logic [IW-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_q <= '0;
    else if (clr_i)  idx_q <= '0;
    else if (inc_i)  idx_q <= idx_q + 1'b1;
  end

  assign idx_o  = idx_q;
  assign last_o = (idx_q == IW'(N-1));

  AST_IDX_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> !inc_i) else $error("identity index wrapped"); // R4

endmodule

// File: rtl/ow_rom_layer.sv
module ow_rom_layer
  import ow_rom_pkg::*;
#(
  parameter logic [7:0]  FAMILY_CODE = 8'h23,
  parameter logic [47:0] SERIAL_NUM  = 48'hA1B2C3D4E5F6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic reset_seen_i,
  input  logic reset_long_i,
  input  logic rx_valid_i,
  input  logic rx_bit_i,
  input  logic tx_req_i,
  output logic tx_bit_o,
  output logic mem_enable_o,
  output logic overdrive_o
);

  localparam int unsigned IW = $clog2(ID_BITS);

  rom_state_e     state_q, state_d;
  search_phase_e  phase_q, phase_d;
  logic           od_q, od_d;
  logic [ID_BITS-1:0]  id;
  logic [IW-1:0]       idx;
  logic                idx_last, idx_clr, idx_inc, id_bit;
  logic                cmd_en, cmd_done;
  logic [CMD_BITS-1:0] cmd_code;

  ow_rom_ident #(
    .FAMILY_CODE (FAMILY_CODE),
    .SERIAL_NUM  (SERIAL_NUM)
  ) u_ident (
    .id_o (id)
  );

  assign cmd_en = (state_q == ST_CMD) && rx_valid_i && !reset_seen_i;

  ow_rom_cmd_rx #(.W(CMD_BITS)) u_cmd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (reset_seen_i),
    .en_i   (cmd_en),
    .bit_i  (rx_bit_i),
    .done_o (cmd_done),
    .code_o (cmd_code)
  );

  ow_rom_index #(.N(ID_BITS)) u_idx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (idx_clr),
    .inc_i  (idx_inc),
    .idx_o  (idx),
    .last_o (idx_last)
  );

  assign id_bit = id[idx];

  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    od_d    = od_q;
    idx_clr = 1'b0;
    idx_inc = 1'b0;
    if (reset_seen_i) begin
      state_d = ST_CMD;
      phase_d = SP_TRUE;
      idx_clr = 1'b1;
      if (reset_long_i) od_d = 1'b0;
    end else begin
      unique case (state_q)
        ST_CMD: if (cmd_done) begin
          idx_clr = 1'b1;
          phase_d = SP_TRUE;
          unique case (cmd_code)
            CMD_READ:     state_d = ST_READ;
            CMD_MATCH:    state_d = ST_MATCH;
            CMD_SEARCH:   state_d = ST_SEARCH;
            CMD_SKIP:     state_d = ST_GRANT;
            CMD_OD_SKIP:  begin state_d = ST_GRANT; od_d = 1'b1; end
            CMD_OD_MATCH: begin state_d = ST_MATCH; od_d = 1'b1; end
            default:      state_d = ST_DROP;
          endcase
        end
        ST_READ: if (tx_req_i) begin
          if (idx_last) state_d = ST_GRANT;
          else          idx_inc = 1'b1;
        end
        ST_MATCH: if (rx_valid_i) begin
          if (rx_bit_i != id_bit) state_d = ST_DROP;
          else if (idx_last)      state_d = ST_GRANT;
          else                    idx_inc = 1'b1;
        end
        ST_SEARCH: begin
          unique case (phase_q)
            SP_TRUE: if (tx_req_i) phase_d = SP_CMPL;
            SP_CMPL: if (tx_req_i) phase_d = SP_DIR;
            default: if (rx_valid_i) begin
              phase_d = SP_TRUE;
              if (rx_bit_i != id_bit) state_d = ST_DROP;
              else if (idx_last)      state_d = ST_GRANT;
              else                    idx_inc = 1'b1;
            end
          endcase
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_WAIT;
      phase_q <= SP_TRUE;
      od_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      od_q    <= od_d;
    end
  end

  always_comb begin
    tx_bit_o = 1'b1;
    if (state_q == ST_READ) tx_bit_o = id_bit;
    else if (state_q == ST_SEARCH && phase_q == SP_TRUE) tx_bit_o = id_bit;
    else if (state_q == ST_SEARCH && phase_q == SP_CMPL) tx_bit_o = ~id_bit;
  end

  assign mem_enable_o = (state_q == ST_GRANT);
  assign overdrive_o  = od_q;

  AST_RESET_REVOKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_seen_i |=> !mem_enable_o) else $error("grant survived reset"); // R14
  AST_OD_LONG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_seen_i && reset_long_i |=> !overdrive_o) else $error("overdrive kept"); // R12
  AST_OD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overdrive_o && !(reset_seen_i && reset_long_i) |=> overdrive_o)
    else $error("overdrive lost"); // R12
  AST_OD_FROM_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !overdrive_o && !cmd_done |=> !overdrive_o) else $error("overdrive set off-command"); // R10
  AST_GRANT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_enable_o && !reset_seen_i |=> mem_enable_o) else $error("grant dropped"); // R9
  AST_DROP_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_DROP && !reset_seen_i |=> state_q == ST_DROP && tx_bit_o)
    else $error("dropped slave active"); // R6

endmodule

// File: tb/ow_rom_layer_tb.sv
module ow_rom_layer_tb;

  localparam logic [7:0]  FAM = 8'h23;
  localparam logic [47:0] SER = 48'h0F1E2D3C4B5A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reset_seen = 1'b0, reset_long = 1'b0;
  logic rx_valid = 1'b0, rx_bit = 1'b0, tx_req = 1'b0;
  logic tx_bit, mem_en, od;

  int checks = 0;
  int errors = 0;
  logic [63:0] ident;
  logic  exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  ow_rom_layer #(.FAMILY_CODE(FAM), .SERIAL_NUM(SER)) u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .reset_seen_i (reset_seen),
    .reset_long_i (reset_long),
    .rx_valid_i   (rx_valid),
    .rx_bit_i     (rx_bit),
    .tx_req_i     (tx_req),
    .tx_bit_o     (tx_bit),
    .mem_enable_o (mem_en),
    .overdrive_o  (od)
  );

  function automatic logic [63:0] build_id(input logic [7:0] f, input logic [47:0] s);
    logic [55:0] b;
    logic [7:0]  c;
    b = {s, f};
    c = 8'h00;
    for (int i = 0; i < 56; i++) begin
      logic x;
      x = c[0] ^ b[i];
      c = c >> 1;
      if (x) c = c ^ 8'h8C;
    end
    return {c, b};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: compares each consumed read slot against the scoreboard
  initial forever begin
    @(negedge clk);
    #1;
    if (tx_req) begin
      if (exp_q.size() == 0) chk("scoreboard", 1, 0);
      else chk(tag_q.pop_front(), {63'd0, tx_bit}, {63'd0, exp_q.pop_front()});
    end
  end

  task automatic bus_reset(input logic lng);
    @(negedge clk); reset_seen = 1'b1; reset_long = lng;
    @(negedge clk); reset_seen = 1'b0; reset_long = 1'b0;
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); rx_valid = 1'b1; rx_bit = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
  endtask

  task automatic read_slot(input logic e, input string tag);
    @(negedge clk); tx_req = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); tx_req = 1'b0;
  endtask

  task automatic send_id(input logic [63:0] v);
    for (int i = 0; i < 64; i++) send_bit(v[i]);
  endtask

  initial begin
    #1_900_000;
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    ident = build_id(FAM, SER);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 mem", {63'd0, mem_en}, 0);
    chk("R1 od", {63'd0, od}, 0);
    chk("R1 tx", {63'd0, tx_bit}, 1);
    send_byte(8'hCC);
    chk("R1 cmd before reset ignored", {63'd0, mem_en}, 0);

    // R4 / R3 read ROM
    bus_reset(1'b1);
    send_byte(8'h33);
    chk("R4 no grant during read", {63'd0, mem_en}, 0);
    for (int i = 0; i < 64; i++) read_slot(ident[i], i >= 56 ? "R3 crc bit" : "R4 id bit");
    chk("R4 grant after read", {63'd0, mem_en}, 1);
    chk("R3 crc residue", {63'd0, build_id(8'h00, 48'd0) == 64'd0}, 1);

    // R2 / R9 skip, 8th bit boundary
    bus_reset(1'b1);
    for (int i = 0; i < 7; i++) send_bit(bit'(8'hCC >> i));
    chk("R2 no decode at 7 bits", {63'd0, mem_en}, 0);
    send_bit(1'b1);
    chk("R9 skip grant", {63'd0, mem_en}, 1);
    repeat (4) @(negedge clk);
    chk("R9 grant holds", {63'd0, mem_en}, 1);

    // R14 reset revokes, partial command discarded
    bus_reset(1'b0);
    chk("R14 grant revoked", {63'd0, mem_en}, 0);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    bus_reset(1'b0);
    send_byte(8'hCC);
    chk("R14 restart after partial", {63'd0, mem_en}, 1);

    // R5 match
    bus_reset(1'b1);
    send_byte(8'h55);
    send_id(ident);
    chk("R5 match grant", {63'd0, mem_en}, 1);
    chk("R5 od untouched", {63'd0, od}, 0);

    // R6 match mismatch
    bus_reset(1'b1);
    send_byte(8'h55);
    send_id(ident ^ (64'd1 << 40));
    chk("R6 mismatch no grant", {63'd0, mem_en}, 0);
    read_slot(1'b1, "R6 silent after drop");
    send_byte(8'hCC);
    chk("R6 cmd ignored after drop", {63'd0, mem_en}, 0);

    // R7 search
    bus_reset(1'b1);
    send_byte(8'hF0);
    for (int i = 0; i < 64; i++) begin
      read_slot(ident[i], "R7 true bit");
      read_slot(~ident[i], "R7 complement bit");
      send_bit(ident[i]);
    end
    chk("R7 search grant", {63'd0, mem_en}, 1);

    // R8 search mismatch at bit 10
    bus_reset(1'b1);
    send_byte(8'hF0);
    for (int i = 0; i < 11; i++) begin
      read_slot(ident[i], "R8 true bit");
      read_slot(~ident[i], "R8 complement bit");
      send_bit(i == 10 ? ~ident[i] : ident[i]);
    end
    read_slot(1'b1, "R8 silent after drop");
    read_slot(1'b1, "R8 silent after drop");
    chk("R8 no grant", {63'd0, mem_en}, 0);

    // R13 unknown code
    bus_reset(1'b1);
    send_byte(8'hA5);
    chk("R13 no grant", {63'd0, mem_en}, 0);
    read_slot(1'b1, "R13 silent");
    send_byte(8'hCC);
    chk("R13 later bits ignored", {63'd0, mem_en}, 0);

    // R10 overdrive skip, R12 persistence
    bus_reset(1'b1);
    send_byte(8'h3C);
    chk("R10 od set", {63'd0, od}, 1);
    chk("R10 grant", {63'd0, mem_en}, 1);
    bus_reset(1'b0);
    chk("R12 od kept short reset", {63'd0, od}, 1);
    send_byte(8'h55);
    send_id(ident);
    chk("R12 od kept through match", {63'd0, od}, 1);
    chk("R5 match in od", {63'd0, mem_en}, 1);
    bus_reset(1'b1);
    chk("R12 od cleared long reset", {63'd0, od}, 0);

    // R11 overdrive match
    send_byte(8'h69);
    chk("R11 od before address", {63'd0, od}, 1);
    chk("R11 no grant yet", {63'd0, mem_en}, 0);
    send_id(ident);
    chk("R11 grant", {63'd0, mem_en}, 1);
    bus_reset(1'b1);
    send_byte(8'h69);
    send_id(~ident);
    chk("R11 mismatch no grant", {63'd0, mem_en}, 0);
    chk("R12 od kept after failed match", {63'd0, od}, 1);

    repeat (3) @(negedge clk);
    chk("scoreboard drained", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule